// File: doc/BRIEF.md
# Synchronous Bridge to an Asynchronous Byte-Wide Memory

This block lets clocked logic read and write a byte-wide, SRAM-compatible nonvolatile memory with 32K locations whose bus has no clock. A request is offered on a valid/ready handshake together with a read/write flag, a 15-bit location and, for writes, a byte. The bridge then walks the memory's strobes through a fixed sequence of phases. Each phase length is a cycle count worked out at elaboration from nanosecond minimums and the clock period, always rounding up. When an access ends, a one-cycle response pulse comes back, carrying the byte for reads.

Reads lower chip enable and output enable together, with write enable high. The returned byte is registered on the last cycle of the access. Writes are timed by write enable. Chip enable falls first. Write enable is then held low for the longest of three limits: the pulse-width minimum, the address-valid-to-end-of-write minimum for output enable high, and the data-setup minimum plus the one cycle in which the data bus is not yet driven. Output enable stays high for the whole write, so the memory's outputs stay floating. After every access both strobes stay high for a recovery period. That period is stretched when needed so that two chip-enable falls are never closer than one minimum cycle.

Back-pressure rules: `req_ready` is high only while the bridge is idle and the power-up guard input `pwr_ok` is high. A request transfers in the cycle where `req_valid` and `req_ready` are both high, and the location and byte are captured in that cycle. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse that the user must take when it comes.

Top module: `async_mem_bridge`

## Requirements
- R1: While reset is asserted and right after it, chip enable, write enable and output enable are high, `mem_dq_oe` and `rsp_valid` are 0, and `req_ready` is 0 until `pwr_ok` is 1.
- R2: While `pwr_ok` is 0, `req_ready` stays 0 and chip enable never falls, even with `req_valid` held at 1.
- R3: A read holds chip enable and output enable low and write enable high for RD = max(ceil(35/T), ceil(15/T)) cycles (T = clock period in ns; 9 at 4 ns). `rsp_valid` rises RD+1 cycles after the handshake cycle.
- R4: A write holds chip enable low with write enable high for SU = max(1, ceil(0/T)) cycles. It then holds write enable low for WP = max(ceil(15/T), ceil(18/T)-SU, ceil(10/T)+1) cycles, with output enable high on every cycle write enable is low. `rsp_valid` rises SU+WP+1 cycles after the handshake.
- R5: `mem_dq_oe` is 1 only while write enable is low, and never in the first cycle of the write pulse. The driven byte is stable for at least 10 ns before write enable rises.
- R6: After an access, chip enable and write enable stay high and the address is held for the recovery count (write: max(ceil(12/T), ceil(2/T), ceil(35/T)-SU-WP); read: max(ceil(2/T), ceil(35/T)-RD)). Successive chip-enable falls are at least ceil(35/T) cycles apart. `req_ready` returns RD+RREC+1 cycles (read) or SU+WP+WREC+1 cycles (write) after the handshake.
- R7: Each accepted request gives exactly one `rsp_valid` pulse, one cycle wide.
- R8: Location and byte are captured at the handshake. Changes to `req_addr`/`req_wdata` after it have no effect on the access in flight.
- R9: A read returns the byte most recently written to that location, or 0x00 for a location never written in the bench's memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_ok | input | 1 | Power-up guard: 1 once the memory may be accessed |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bridge idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Memory location |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte read (valid with rsp_valid after a read) |
| mem_addr | output | 15 | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Byte driven onto the shared data bus |
| mem_dq_oe | output | 1 | 1 = bridge drives the data bus |
| mem_dq_in | input | 8 | Byte sampled from the shared data bus |

## Verification
The assertions check, on every cycle, the rules between strobes: output enable is high whenever write enable is low, write enable is never low without chip enable, and the bus is driven only inside the write pulse. They also check that the address moves only at a handshake, that chip enable never falls without the power guard, that the response pulse is one cycle wide, and that chip-enable falls are spaced far enough apart. Only the bench scenarios can show the nanosecond margins: access time before capture, pulse width, address-to-end-of-write, data setup and address recovery. These are measured by a behavioural memory that returns unknown data when a read is sampled early. The bench also shows the exact latencies and the byte integrity over random mixes of reads and writes.

// File: rtl/amb_pkg.sv
package amb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WSU  = 3'd2,
    ST_WPUL = 3'd3,
    ST_REC  = 3'd4
  } seq_st_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int per_ns);
    int c;
    if (ns <= 0) return 1;
    c = (ns + per_ns - 1) / per_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/amb_phase_timer.sv
module amb_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/amb_sequencer.sv
module amb_sequencer
  import amb_pkg::*;
#(
  parameter int RD_CYC   = 9,
  parameter int SU_CYC   = 1,
  parameter int WP_CYC   = 4,
  parameter int WREC_CYC = 4,
  parameter int RREC_CYC = 1,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_ok,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_zero,
  output logic             req_ready,
  output logic             accept,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output seq_st_e          state_q,
  output seq_st_e          nxt_state,
  output logic             rd_capture,
  output logic             wr_done
);
  localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_SU   = CNT_W'(SU_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WP   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WREC = CNT_W'(WREC_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RREC = CNT_W'(RREC_CYC - 1);

  assign req_ready = (state_q == ST_IDLE) && pwr_ok;
  assign accept    = req_ready && req_valid;

  always_comb begin
    nxt_state  = state_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    rd_capture = 1'b0;
    wr_done    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        tmr_load  = 1'b1;
        nxt_state = req_write ? ST_WSU : ST_RD;
        tmr_val   = req_write ? LD_SU : LD_RD;
      end
      ST_RD: if (tmr_zero) begin
        rd_capture = 1'b1;
        nxt_state  = ST_REC;
        tmr_load   = 1'b1;
        tmr_val    = LD_RREC;
      end
      ST_WSU: if (tmr_zero) begin
        nxt_state = ST_WPUL;
        tmr_load  = 1'b1;
        tmr_val   = LD_WP;
      end
      ST_WPUL: if (tmr_zero) begin
        wr_done   = 1'b1;
        nxt_state = ST_REC;
        tmr_load  = 1'b1;
        tmr_val   = LD_WREC;
      end
      ST_REC: if (tmr_zero) nxt_state = ST_IDLE;
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= nxt_state;
  end
endmodule

// File: rtl/amb_pin_driver.sv
module amb_pin_driver
  import amb_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_st_e           state_q,
  input  seq_st_e           nxt_state,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);
  logic nxt_sel, nxt_we, nxt_oe, nxt_drive;

  // pins follow the state the sequencer enters, so they change on the same edge
  always_comb begin
    nxt_sel   = (nxt_state == ST_RD) || (nxt_state == ST_WSU) || (nxt_state == ST_WPUL);
    nxt_we    = (nxt_state == ST_WPUL);
    nxt_oe    = (nxt_state == ST_RD);
    nxt_drive = (nxt_state == ST_WPUL) && (state_q == ST_WPUL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_ce_n  <= ~nxt_sel;
      mem_we_n  <= ~nxt_we;
      mem_oe_n  <= ~nxt_oe;
      mem_dq_oe <= nxt_drive;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      if (req_write) mem_dq_out <= req_wdata;
    end
  end
endmodule

// File: rtl/amb_rd_capture.sv
module amb_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_capture,
  input  logic              wr_done,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_capture | wr_done;
      if (rd_capture) rsp_rdata <= mem_dq_in;
    end
  end
endmodule

// File: rtl/async_mem_bridge.sv
module async_mem_bridge
  import amb_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_CYCLE_NS    = 35,
  parameter int T_ACC_ADDR_NS = 35,
  parameter int T_ACC_OE_NS   = 15,
  parameter int T_AS_NS       = 0,
  parameter int T_WP_NS       = 15,
  parameter int T_AW_NS       = 18,
  parameter int T_DS_NS       = 10,
  parameter int T_WR_NS       = 12,
  parameter int T_HIGH_NS     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int P        = CLK_PERIOD_NS;
  localparam int RD_CYC   = imax(ns2cyc(T_ACC_ADDR_NS, P), ns2cyc(T_ACC_OE_NS, P));
  localparam int SU_CYC   = ns2cyc(T_AS_NS, P);
  // data bus is driven one cycle after the fall, hence the extra cycle on setup
  localparam int WP_CYC   = imax(imax(ns2cyc(T_WP_NS, P), ns2cyc(T_AW_NS, P) - SU_CYC),
                                 ns2cyc(T_DS_NS, P) + 1);
  localparam int WREC_CYC = imax(imax(ns2cyc(T_WR_NS, P), ns2cyc(T_HIGH_NS, P)),
                                 ns2cyc(T_CYCLE_NS, P) - SU_CYC - WP_CYC);
  localparam int RREC_CYC = imax(ns2cyc(T_HIGH_NS, P), ns2cyc(T_CYCLE_NS, P) - RD_CYC);
  localparam int MAX_CYC  = imax(imax(imax(RD_CYC, SU_CYC), imax(WP_CYC, WREC_CYC)), RREC_CYC);
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  seq_st_e          state_q, nxt_state;
  logic             accept, tmr_load, tmr_zero, rd_capture, wr_done;
  logic [CNT_W-1:0] tmr_val;

  amb_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  amb_sequencer #(
    .RD_CYC(RD_CYC), .SU_CYC(SU_CYC), .WP_CYC(WP_CYC),
    .WREC_CYC(WREC_CYC), .RREC_CYC(RREC_CYC), .CNT_W(CNT_W)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_ok     (pwr_ok),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .tmr_zero   (tmr_zero),
    .req_ready  (req_ready),
    .accept     (accept),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .state_q    (state_q),
    .nxt_state  (nxt_state),
    .rd_capture (rd_capture),
    .wr_done    (wr_done)
  );

  amb_pin_driver #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) pins_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_q    (state_q),
    .nxt_state  (nxt_state),
    .accept     (accept),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

  amb_rd_capture #(.DATA_W(DATA_W)) cap_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_capture (rd_capture),
    .wr_done    (wr_done),
    .mem_dq_in  (mem_dq_in),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );
endmodule

// File: rtl/amb_checker.sv
module amb_checker #(
  parameter int ADDR_W        = 15,
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_CYCLE_NS    = 35
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_ok,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);
  localparam int MIN_GAP = (T_CYCLE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

  logic [7:0] gap_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                          gap_q <= 8'hFF;
    else if (!mem_ce_n && $past(mem_ce_n)) gap_q <= 8'd1;
    else if (gap_q != 8'hFF)             gap_q <= gap_q + 8'd1;
  end

  p_no_start_unpowered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> $past(pwr_ok));

  p_we_inside_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  p_oe_high_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  p_drive_in_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && $past(!mem_we_n)));

  p_addr_moves_at_handshake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> $past(req_valid && req_ready));

  p_ce_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (gap_q >= 8'(MIN_GAP)));

  p_rsp_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_ready_when_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && !mem_dq_oe));
endmodule

bind async_mem_bridge amb_checker #(
  .ADDR_W(ADDR_W), .CLK_PERIOD_NS(CLK_PERIOD_NS), .T_CYCLE_NS(T_CYCLE_NS)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_ok    (pwr_ok),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/async_mem_bridge_tb_top.sv
`timescale 1ns/1ps
module async_mem_bridge_tb_top;
  localparam int T = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_ok = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 'x;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  async_mem_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  function automatic int cdiv(int ns);
    int c;
    c = (ns + T - 1) / T;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // expected counts derived from the requirement text
  int e_rd, e_su, e_wp, e_wrec, e_rrec, e_gap;
  initial begin
    e_rd   = mx(cdiv(35), cdiv(15));
    e_su   = 1;
    e_wp   = mx(mx(cdiv(15), cdiv(18) - e_su), cdiv(10) + 1);
    e_wrec = mx(mx(cdiv(12), cdiv(2)), cdiv(35) - e_su - e_wp);
    e_rrec = mx(cdiv(2), cdiv(35) - e_rd);
    e_gap  = cdiv(35);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // ---------------- behavioural memory with timing monitors ----------------
  logic [7:0] mem [int];
  logic [7:0] ref_mem [int];
  logic [14:0] p_addr = '0;
  logic        p_ce_n = 1'b1, p_we_n = 1'b1, p_oe_n = 1'b1, p_dq_oe = 1'b0;
  logic [7:0]  p_dq = '0;
  int addr_age = 1000, since_we_rise = 1000, since_ce_fall = 1000;
  int we_cnt = 0, dq_age = 0, p_dq_age = 0, rd_age = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_addr != p_addr) begin
        check(since_we_rise * T >= 12, "R6", "addr hold after write (ns)", since_we_rise * T, 12);
        addr_age = 1;
      end else if (addr_age < 1000) addr_age++;
      if (since_we_rise < 1000) since_we_rise++;
      if (since_ce_fall < 1000) since_ce_fall++;
      if (!mem_ce_n && p_ce_n) begin
        check(since_ce_fall >= e_gap, "R6", "chip enable fall spacing", since_ce_fall, e_gap);
        since_ce_fall = 0;
      end
      if (!mem_we_n) begin
        we_cnt = p_we_n ? 1 : we_cnt + 1;
        if (!mem_oe_n) check(1'b0, "R4", "output enable low in write", 0, 1);
        if (mem_dq_oe && p_we_n) check(1'b0, "R5", "bus driven in first pulse cycle", 1, 0);
      end
      p_dq_age = dq_age;
      if (mem_dq_oe) begin
        dq_age = (!p_dq_oe || mem_dq_out != p_dq) ? 1 : dq_age + 1;
        if (mem_we_n) check(1'b0, "R5", "bus driven with write enable high", 1, 0);
      end else dq_age = 0;
      if (mem_we_n && !p_we_n) begin
        check(we_cnt * T >= 15, "R4", "write pulse width (ns)", we_cnt * T, 15);
        check((addr_age - 1) * T >= 18, "R4", "addr valid to end of write (ns)", (addr_age - 1) * T, 18);
        check(p_dq_age * T >= 10, "R5", "data setup (ns)", p_dq_age * T, 10);
        check(!p_ce_n, "R4", "chip enable low during write", p_ce_n, 0);
        mem[int'(p_addr)] = p_dq;
        since_we_rise = 0;
      end
      if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
        rd_age = (mem_addr != p_addr || p_ce_n || p_oe_n) ? 1 : rd_age + 1;
        if (rd_age * T >= 35 && rd_age * T >= 15)
          mem_dq_in = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
        else mem_dq_in = 'x;
      end else begin
        rd_age = 0;
        mem_dq_in = 'x;
      end
      p_addr = mem_addr; p_ce_n = mem_ce_n; p_we_n = mem_we_n;
      p_oe_n = mem_oe_n; p_dq_oe = mem_dq_oe; p_dq = mem_dq_out;
    end
  end

  // ---------------- request driver ----------------
  task automatic do_req(input bit wr, input logic [14:0] a, input logic [7:0] d);
    int lat, tot;
    logic [7:0] exp_b;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    // R8: scramble the inputs right after the handshake
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
    lat = 1;
    while (!rsp_valid && lat < 100) begin @(negedge clk); lat++; end
    if (wr) begin
      check(lat == e_su + e_wp + 1, "R4", "write response latency", lat, e_su + e_wp + 1);
      ref_mem[int'(a)] = d;
    end else begin
      check(lat == e_rd + 1, "R3", "read response latency", lat, e_rd + 1);
      exp_b = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
      check(rsp_rdata === exp_b, "R9", "read data (R8 capture)", int'(rsp_rdata), int'(exp_b));
    end
    @(negedge clk);
    tot = lat + 1;
    check(!rsp_valid, "R7", "response pulse width", rsp_valid, 0);
    while (!req_ready && tot < 100) begin @(negedge clk); tot++; end
    if (wr) check(tot == e_su + e_wp + e_wrec + 1, "R6", "write occupancy", tot, e_su + e_wp + e_wrec + 1);
    else    check(tot == e_rd + e_rrec + 1, "R6", "read occupancy", tot, e_rd + e_rrec + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1..all: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    bit ok;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(mem_ce_n && mem_we_n && mem_oe_n, "R1", "strobes high in reset",
          {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    check(!mem_dq_oe && !rsp_valid && !req_ready, "R1", "outputs idle in reset",
          {mem_dq_oe, rsp_valid, req_ready}, 0);
    rst_n = 1'b1;
    // R2: request held while the power guard is low
    req_valid = 1'b1; req_addr = 15'h0123; req_write = 1'b1; req_wdata = 8'h5A;
    ok = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (req_ready || !mem_ce_n) ok = 1'b0;
    end
    check(ok, "R2", "no start while unpowered", ok, 1);
    check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1", "strobes high after reset", mem_ce_n, 1);
    req_valid = 1'b0;
    pwr_ok = 1'b1;
    @(negedge clk);
    check(req_ready, "R2", "ready once powered", req_ready, 1);
    // directed corners
    do_req(1'b0, 15'h0123, 8'h00);             // unwritten location
    do_req(1'b1, 15'h0000, 8'hFF);
    do_req(1'b1, 15'h7FFF, 8'h00);
    do_req(1'b0, 15'h0000, 8'h00);
    do_req(1'b0, 15'h7FFF, 8'h00);
    do_req(1'b1, 15'h0000, 8'hA5);             // overwrite
    do_req(1'b1, 15'h0001, 8'h3C);             // back-to-back writes
    do_req(1'b0, 15'h0000, 8'h00);
    do_req(1'b0, 15'h0001, 8'h00);
    // random mix on a small window so reads hit written bytes
    for (int n = 0; n < 300; n++) begin
      logic [14:0] a;
      a = 15'($urandom_range(0, 31)) | ((n % 4 == 0) ? 15'h7FE0 : 15'h0);
      do_req(1'($urandom_range(0, 1)), a, 8'($urandom));
    end
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule